// File: doc/BRIEF.md
# Branch Checkpoint Rename Table

This block holds the live architectural-to-physical register map of a renaming stage and a small file of full map snapshots used for branch recovery. Each renamed branch asks for a snapshot slot and gets back a tag. The tag travels with the branch until the branch resolves. A correct resolve gives the slot back at once, whether or not older branches are still pending. A misprediction copies that branch's own snapshot into the live map in one cycle. It also drops the slot and every slot taken by a younger branch.

The slots are indexed directly, like a small register file, so any snapshot can be restored without walking a queue. Relative age between slots is kept in an age matrix. In a single cycle the renamer may write several mappings and place a branch between them. A cut position says which writes belong in that branch's snapshot. Squashes that do not come from branches are handled elsewhere and do not use these snapshots.

Top module: `ckpt_table`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i, no snapshot slot is held, and `full_o` is low.
- R2: Each enabled write port updates the live map, and the change is visible on the lookup ports in the next cycle. When two ports write the same architectural register in one cycle, the higher-numbered port wins.
- R3: A lookup port returns the live map as it stood at the start of the cycle. Writes made in the same cycle are not forwarded.
- R4: A granted snapshot holds the live map plus only those same-cycle writes whose port number is below `br_cut_i`. A misprediction on a held tag makes the live map equal to that snapshot from the next cycle on.
- R5: A branch request is granted in the same cycle when a slot is free and no misprediction is signalled. `br_tag_o` is the index of the lowest-numbered free slot.
- R6: Rename writes presented in the same cycle as a misprediction on a held tag are discarded.
- R7: A correct resolve frees only the named slot, and it does so immediately, even while older slots remain held.
- R8: `full_o` is high exactly when all slots are held. While full, a request is not granted unless R9 applies.
- R9: A correct resolve presented together with a request makes the named slot available to that same request.
- R10: A misprediction frees its own slot and every slot allocated after it. Slots allocated before it stay held.
- R11: A request presented in the same cycle as a misprediction is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | WR_PORTS | Per-port rename write enable, lower port is older |
| wr_addr_i | input | WR_PORTS x AW | Architectural register written by each port |
| wr_data_i | input | WR_PORTS x PHYS_W | New physical name for each port |
| rd_addr_i | input | RD_PORTS x AW | Lookup addresses |
| rd_data_o | output | RD_PORTS x PHYS_W | Current physical names |
| br_req_i | input | 1 | Branch asks for a snapshot slot |
| br_cut_i | input | CW | Number of write ports older than the branch |
| br_gnt_o | output | 1 | Slot granted this cycle |
| br_tag_o | output | IW | Granted slot index |
| full_o | output | 1 | Every slot is held |
| res_valid_i | input | 1 | Branch resolution this cycle |
| res_tag_i | input | IW | Tag of the resolving branch |
| res_mispred_i | input | 1 | Resolution is a misprediction |

## Verification
Two functions can land on the same slot in one cycle: resolve and allocation. The bench provokes this by filling every slot and then raising a correct resolve of slot 5 together with a new request. It expects tag 5 to be granted at once while `full_o` stays high. It also presents a request together with a misprediction and expects no grant. It then checks that the next free request gets the freed slot, which confirms that the misprediction released it and that the suppressed request took nothing. A third overlap places a rename write inside a restore cycle, and the bench expects that write to vanish from the map.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  localparam int unsigned DEF_ARCH_REGS = 32;
  localparam int unsigned DEF_PHYS_W    = 7;
  localparam int unsigned DEF_NUM_CKPT  = 16;
  localparam int unsigned DEF_WR_PORTS  = 2;
  localparam int unsigned DEF_RD_PORTS  = 4;

  typedef enum logic [1:0] {
    RES_NONE   = 2'b00,
    RES_OK     = 2'b01,
    RES_FLUSH  = 2'b11
  } res_kind_e;
endpackage

// File: rtl/ckpt_pick.sv
module ckpt_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  free_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ckpt_age.sv
module ckpt_age #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [IW-1:0] alloc_idx_i,
  input  ckpt_pkg::res_kind_e res_i,
  input  logic [IW-1:0] res_idx_i,
  output logic [N-1:0]  held_o,
  output logic [N-1:0]  free_o
);
  // older_q[i][j]: slot i was taken before slot j
  logic [N-1:0][N-1:0] older_q;
  logic [N-1:0]        held_q, rel_mask, kill_mask, held_mid;

  always_comb begin
    rel_mask  = (res_i != ckpt_pkg::RES_NONE) ? (N'(1) << res_idx_i) : '0;
    kill_mask = '0;
    if (res_i == ckpt_pkg::RES_FLUSH && held_q[res_idx_i])
      kill_mask = older_q[res_idx_i] & held_q;
    held_mid = held_q & ~rel_mask & ~kill_mask;
  end

  assign free_o = ~held_mid;
  assign held_o = held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= '0;
      older_q <= '0;
    end else begin
      held_q <= held_mid | (alloc_i ? (N'(1) << alloc_idx_i) : '0);
      if (alloc_i) begin
        older_q[alloc_idx_i] <= '0;
        for (int j = 0; j < N; j++) older_q[j][alloc_idx_i] <= held_mid[j];
      end
    end
  end
endmodule

// File: rtl/ckpt_maps.sv
module ckpt_maps #(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned PHYS_W    = 7,
  parameter int unsigned N         = 16,
  parameter int unsigned WR_PORTS  = 2,
  parameter int unsigned RD_PORTS  = 4,
  parameter int unsigned AW        = $clog2(ARCH_REGS),
  parameter int unsigned IW        = $clog2(N),
  parameter int unsigned CW        = $clog2(WR_PORTS + 1)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [WR_PORTS-1:0]                wr_en_i,
  input  logic [WR_PORTS-1:0][AW-1:0]        wr_addr_i,
  input  logic [WR_PORTS-1:0][PHYS_W-1:0]    wr_data_i,
  input  logic                               snap_i,
  input  logic [IW-1:0]                      snap_idx_i,
  input  logic [CW-1:0]                      snap_cut_i,
  input  logic                               restore_i,
  input  logic [IW-1:0]                      restore_idx_i,
  input  logic [RD_PORTS-1:0][AW-1:0]        rd_addr_i,
  output logic [RD_PORTS-1:0][PHYS_W-1:0]    rd_data_o,
  output logic [ARCH_REGS-1:0][PHYS_W-1:0]   live_o,
  output logic [ARCH_REGS-1:0][PHYS_W-1:0]   restore_map_o
);
  logic [ARCH_REGS-1:0][PHYS_W-1:0] live_q, all_v, cut_v;
  logic [ARCH_REGS-1:0][PHYS_W-1:0] snap_q [N];

  always_comb begin
    all_v = live_q;
    cut_v = live_q;
    for (int p = 0; p < WR_PORTS; p++) begin
      if (wr_en_i[p]) begin
        all_v[wr_addr_i[p]] = wr_data_i[p];
        if (CW'(p) < snap_cut_i) cut_v[wr_addr_i[p]] = wr_data_i[p];
      end
    end
  end

  assign restore_map_o = snap_q[restore_idx_i];
  assign live_o        = live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_REGS; i++) live_q[i] <= PHYS_W'(i);
    end else if (restore_i) begin
      live_q <= restore_map_o;
    end else begin
      live_q <= all_v;
    end
  end

  always_ff @(posedge clk_i) begin
    if (snap_i) snap_q[snap_idx_i] <= cut_v;
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    assign rd_data_o[r] = live_q[rd_addr_i[r]];
  end
endmodule

// File: rtl/ckpt_table.sv
module ckpt_table #(
  parameter int unsigned ARCH_REGS = ckpt_pkg::DEF_ARCH_REGS,
  parameter int unsigned PHYS_W    = ckpt_pkg::DEF_PHYS_W,
  parameter int unsigned NUM_CKPT  = ckpt_pkg::DEF_NUM_CKPT,
  parameter int unsigned WR_PORTS  = ckpt_pkg::DEF_WR_PORTS,
  parameter int unsigned RD_PORTS  = ckpt_pkg::DEF_RD_PORTS,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned IW = $clog2(NUM_CKPT),
  localparam int unsigned CW = $clog2(WR_PORTS + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [WR_PORTS-1:0]             wr_en_i,
  input  logic [WR_PORTS-1:0][AW-1:0]     wr_addr_i,
  input  logic [WR_PORTS-1:0][PHYS_W-1:0] wr_data_i,
  input  logic [RD_PORTS-1:0][AW-1:0]     rd_addr_i,
  output logic [RD_PORTS-1:0][PHYS_W-1:0] rd_data_o,
  input  logic                            br_req_i,
  input  logic [CW-1:0]                   br_cut_i,
  output logic                            br_gnt_o,
  output logic [IW-1:0]                   br_tag_o,
  output logic                            full_o,
  input  logic                            res_valid_i,
  input  logic [IW-1:0]                   res_tag_i,
  input  logic                            res_mispred_i
);
  ckpt_pkg::res_kind_e res_kind;
  logic [NUM_CKPT-1:0] held, free_slots;
  logic found, flush, restore;
  logic [WR_PORTS-1:0] wr_en_eff;
  logic [ARCH_REGS-1:0][PHYS_W-1:0] live, restore_map;

  always_comb begin
    res_kind = ckpt_pkg::RES_NONE;
    if (res_valid_i) res_kind = res_mispred_i ? ckpt_pkg::RES_FLUSH : ckpt_pkg::RES_OK;
  end

  assign flush     = (res_kind == ckpt_pkg::RES_FLUSH);
  assign restore   = flush && held[res_tag_i];
  assign br_gnt_o  = br_req_i && found && !flush;
  assign full_o    = &held;
  assign wr_en_eff = restore ? '0 : wr_en_i;

  ckpt_pick #(.N(NUM_CKPT), .IW(IW)) u_pick (
    .free_i (free_slots),
    .found_o(found),
    .idx_o  (br_tag_o)
  );

  ckpt_age #(.N(NUM_CKPT), .IW(IW)) u_age (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (br_gnt_o),
    .alloc_idx_i(br_tag_o),
    .res_i      (res_kind),
    .res_idx_i  (res_tag_i),
    .held_o     (held),
    .free_o     (free_slots)
  );

  ckpt_maps #(
    .ARCH_REGS(ARCH_REGS), .PHYS_W(PHYS_W), .N(NUM_CKPT),
    .WR_PORTS(WR_PORTS), .RD_PORTS(RD_PORTS)
  ) u_maps (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_eff),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .snap_i       (br_gnt_o),
    .snap_idx_i   (br_tag_o),
    .snap_cut_i   (br_cut_i),
    .restore_i    (restore),
    .restore_idx_i(res_tag_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .live_o       (live),
    .restore_map_o(restore_map)
  );
endmodule

// File: rtl/ckpt_table_chk.sv
module ckpt_table_chk #(
  parameter int unsigned ARCH_REGS = 32,
  parameter int unsigned PHYS_W    = 7,
  parameter int unsigned NUM_CKPT  = 16,
  parameter int unsigned IW        = $clog2(NUM_CKPT)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             br_req_i,
  input logic                             br_gnt_o,
  input logic [IW-1:0]                    br_tag_o,
  input logic                             full_o,
  input logic                             res_valid_i,
  input logic [IW-1:0]                    res_tag_i,
  input logic                             res_mispred_i,
  input logic [NUM_CKPT-1:0]              held,
  input logic                             restore,
  input logic [ARCH_REGS-1:0][PHYS_W-1:0] live,
  input logic [ARCH_REGS-1:0][PHYS_W-1:0] restore_map
);
  assert_grant_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_gnt_o |-> (!held[br_tag_o] ||
                  (res_valid_i && !res_mispred_i && res_tag_i == br_tag_o)));

  assert_req_served_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_req_i && !full_o && !res_valid_i) |-> br_gnt_o);

  assert_full_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !(res_valid_i && !res_mispred_i)) |-> !br_gnt_o);

  assert_restore_map_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore |=> (live == $past(restore_map)));

  assert_release_now_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_mispred_i && !(br_gnt_o && br_tag_o == res_tag_i))
      |=> !held[$past(res_tag_i)]);

  assert_flush_shrinks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore |=> ($countones(held) < $past($countones(held))));

  assert_no_grant_on_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_mispred_i) |-> !br_gnt_o);
endmodule

bind ckpt_table ckpt_table_chk #(
  .ARCH_REGS(ARCH_REGS), .PHYS_W(PHYS_W), .NUM_CKPT(NUM_CKPT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .br_req_i     (br_req_i),
  .br_gnt_o     (br_gnt_o),
  .br_tag_o     (br_tag_o),
  .full_o       (full_o),
  .res_valid_i  (res_valid_i),
  .res_tag_i    (res_tag_i),
  .res_mispred_i(res_mispred_i),
  .held         (held),
  .restore      (restore),
  .live         (live),
  .restore_map  (restore_map)
);

// File: tb/ckpt_table_test.sv
`timescale 1ns/1ps
module ckpt_table_test;
  localparam int NC = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0]      wr_en_i;
  logic [1:0][4:0] wr_addr_i;
  logic [1:0][6:0] wr_data_i;
  logic [3:0][4:0] rd_addr_i;
  logic [3:0][6:0] rd_data_o;
  logic br_req_i, br_gnt_o, full_o, res_valid_i, res_mispred_i;
  logic [1:0] br_cut_i;
  logic [3:0] br_tag_o, res_tag_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ckpt_table uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .br_req_i(br_req_i), .br_cut_i(br_cut_i), .br_gnt_o(br_gnt_o),
    .br_tag_o(br_tag_o), .full_o(full_o),
    .res_valid_i(res_valid_i), .res_tag_i(res_tag_i), .res_mispred_i(res_mispred_i)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = '0; wr_addr_i = '0; wr_data_i = '0;
    br_req_i = 0; br_cut_i = '0; res_valid_i = 0; res_tag_i = '0; res_mispred_i = 0;
  endtask

  task automatic start_cyc();
    @(negedge clk);
  endtask

  task automatic end_cyc();
    @(posedge clk);
    #0.5;
    idle();
  endtask

  task automatic read_chk(input string req, input int port, input int a, input int exp);
    rd_addr_i[port] = 5'(a);
    #0.1;
    chk(req, int'(rd_data_o[port]), exp);
  endtask

  task automatic alloc_chk(input string req, input int exp_tag);
    start_cyc();
    br_req_i = 1;
    #0.5;
    chk({req, " grant"}, int'(br_gnt_o), 1);
    chk({req, " tag"}, int'(br_tag_o), exp_tag);
    end_cyc();
  endtask

  task automatic resolve(input int tag, input bit mis);
    start_cyc();
    res_valid_i = 1; res_tag_i = 4'(tag); res_mispred_i = mis;
    end_cyc();
  endtask

  task automatic t_reset();
    chk("R1 full low", int'(full_o), 0);
    for (int a = 0; a < 32; a++) read_chk("R1 identity map", 0, a, a);
  endtask

  task automatic t_write();
    start_cyc();
    wr_en_i = 2'b11;
    wr_addr_i[0] = 5; wr_data_i[0] = 40;
    wr_addr_i[1] = 5; wr_data_i[1] = 41;
    rd_addr_i[0] = 5;
    #0.5;
    chk("R3 no same-cycle forward", int'(rd_data_o[0]), 5);
    end_cyc();
    read_chk("R2 higher port wins", 0, 5, 41);
    start_cyc();
    wr_en_i = 2'b01; wr_addr_i[0] = 6; wr_data_i[0] = 42;
    end_cyc();
    read_chk("R2 single write", 1, 6, 42);
  endtask

  task automatic t_snapshot();
    start_cyc();
    br_req_i = 1; br_cut_i = 2'd1;
    wr_en_i = 2'b11;
    wr_addr_i[0] = 7; wr_data_i[0] = 50;
    wr_addr_i[1] = 8; wr_data_i[1] = 51;
    #0.5;
    chk("R5 first tag", int'(br_tag_o), 0);
    end_cyc();
    read_chk("R2 live after branch cycle", 0, 8, 51);
    start_cyc();
    wr_en_i = 2'b11;
    wr_addr_i[0] = 7; wr_data_i[0] = 60;
    wr_addr_i[1] = 5; wr_data_i[1] = 61;
    end_cyc();
    start_cyc();
    res_valid_i = 1; res_tag_i = 0; res_mispred_i = 1;
    wr_en_i = 2'b01; wr_addr_i[0] = 9; wr_data_i[0] = 70;
    end_cyc();
    read_chk("R4 older write kept", 0, 7, 50);
    read_chk("R4 younger write excluded", 1, 8, 8);
    read_chk("R4 prior mapping restored", 2, 5, 41);
    read_chk("R6 write in restore cycle dropped", 3, 9, 9);
  endtask

  task automatic t_order();
    alloc_chk("R5 lowest", 0);
    alloc_chk("R5 lowest", 1);
    alloc_chk("R5 lowest", 2);
    resolve(1, 0);
    alloc_chk("R7 out-of-order release", 1);
    resolve(0, 1);
    alloc_chk("R10 flush of oldest frees all", 0);
    resolve(0, 0);
  endtask

  task automatic t_younger();
    for (int k = 0; k < 4; k++) alloc_chk("R5 fill", k);
    resolve(1, 1);
    alloc_chk("R10 younger freed", 1);
    alloc_chk("R10 younger freed", 2);
    alloc_chk("R10 younger freed", 3);
    alloc_chk("R10 older kept", 4);
    resolve(0, 1);
    alloc_chk("R10 cleanup", 0);
    resolve(0, 0);
  endtask

  task automatic t_flush_alloc();
    alloc_chk("R5 setup", 0);
    start_cyc();
    res_valid_i = 1; res_tag_i = 0; res_mispred_i = 1; br_req_i = 1;
    #0.5;
    chk("R11 no grant on mispredict", int'(br_gnt_o), 0);
    end_cyc();
    alloc_chk("R11 slot freed nothing taken", 0);
    resolve(0, 0);
  endtask

  task automatic t_full();
    for (int k = 0; k < NC; k++) alloc_chk("R5 fill all", k);
    #0.1;
    chk("R8 full high", int'(full_o), 1);
    start_cyc();
    br_req_i = 1;
    #0.5;
    chk("R8 no grant when full", int'(br_gnt_o), 0);
    end_cyc();
    start_cyc();
    br_req_i = 1; res_valid_i = 1; res_tag_i = 5; res_mispred_i = 0;
    #0.5;
    chk("R9 same-cycle grant", int'(br_gnt_o), 1);
    chk("R9 same-cycle tag", int'(br_tag_o), 5);
    end_cyc();
    chk("R9 still full", int'(full_o), 1);
    resolve(0, 1);
    #0.1;
    chk("R10 full cleared", int'(full_o), 0);
  endtask

  initial begin
    idle();
    rd_addr_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_write();
    t_snapshot();
    t_order();
    t_younger();
    t_flush_alloc();
    t_full();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule